// File: doc/BRIEF.md
# Automatic Standard Select Hunter

This block picks which of up to four input standards a downstream receive path should try. It drives a 2-bit select code to an external rate selector or reclocker. While no valid timing reference is seen, it holds each code for a programmable number of clock cycles and then moves on to the next code. After code 3 it returns to code 0. When a valid sync arrives, the hunt stops on the current code and a locked status is raised.

Once locked, every valid sync restarts a supervision window. If a fixed number of hunt periods pass with no valid sync, the lock is released and hunting starts again from the code that was held. An explicit sync-lost indication releases the lock at once. A low enable freezes the whole block, so the select outputs may be disregarded during that time.

Top module: `std_select_hunter`

## Requirements
- R1: While rst_ni is low and after it is released, code_o reads 2'b00 and locked_o reads 0.
- R2: While enabled and not locked, each code value stays on code_o for exactly P cycles with no valid sync and then increases by one. P is the value of period_i, and a period_i of 0 counts as 1.
- R3: The code advances in binary order 0,1,2,3 and wraps from 3 back to 0. No other change of code_o occurs.
- R4: A sync_valid_i sampled high while enabled sets locked_o on the next cycle. The code that was on code_o at that time is kept.
- R5: If sync_valid_i arrives in the cycle in which the hunt period on the current code expires, the lock wins and the code does not advance. locked_o only rises after a sampled sync_valid_i.
- R6: While locked_o is high, code_o does not change. Each sync_valid_i restarts the loss timeout from zero.
- R7: While locked, LOST_PERIODS (default 4) consecutive hunt periods of P cycles with no sync_valid_i clear locked_o. Hunting then resumes from the held code, and its next advance comes P cycles later.
- R8: sync_lost_i sampled high while locked and enabled clears locked_o on the next cycle, keeps the code, and starts a fresh full period. If sync_valid_i is high in the same cycle, the lock is kept.
- R9: sync_lost_i has no effect while not locked: code stepping continues on schedule.
- R10: While enable_i is low, code_o, locked_o and all timers hold their values, and sync_valid_i and sync_lost_i are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Function enable; low freezes all state |
| sync_valid_i | input | 1 | Single-cycle pulse for a valid timing reference |
| sync_lost_i | input | 1 | Sync-lost indication; releases a held lock |
| period_i | input | PERIOD_W | Hunt period in clock cycles (0 treated as 1) |
| code_o | output | 2 | Standard select code |
| locked_o | output | 1 | High while the hunt is frozen on a found standard |

## Verification
Two events can fall in the same cycle: the expiry of the dwell timer and an arriving valid sync. The second pair is sync-lost and sync-valid while locked. Directed steps pulse sync_valid_i exactly on the last cycle of a hunt period, and then raise sync_valid_i together with sync_lost_i while locked. The expected outcome in both cases is that the lock wins and the code stays put. Random traffic with short periods, including a period of 0, makes the same collisions occur many more times. A cycle model in the bench judges every one of them.

// File: rtl/shs_pkg.sv
`timescale 1ns/1ps
package shs_pkg;
  localparam int unsigned CODE_W = 2;
  typedef logic [CODE_W-1:0] code_t;
endpackage

// File: rtl/shs_dwell_timer.sv
`timescale 1ns/1ps
module shs_dwell_timer #(
  parameter int unsigned PERIOD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                clear_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                expire_o
);
  localparam logic [PERIOD_W-1:0] ONE = PERIOD_W'(1);

  logic [PERIOD_W-1:0] dwell_q;
  logic [PERIOD_W-1:0] limit;

  // zero period behaves as one cycle
  assign limit    = (period_i == '0) ? '0 : period_i - ONE;
  assign expire_o = run_i && !clear_i && (dwell_q >= limit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dwell_q <= '0;
    end else if (run_i) begin
      if (clear_i || expire_o) dwell_q <= '0;
      else                     dwell_q <= dwell_q + ONE;
    end
  end
endmodule

// File: rtl/shs_code_counter.sv
`timescale 1ns/1ps
module shs_code_counter
  import shs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  step_i,
  output code_t code_o
);
  localparam code_t STEP = code_t'(1);

  code_t code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     code_q <= '0;
    else if (step_i) code_q <= code_q + STEP;  // wraps naturally
  end

  assign code_o = code_q;
endmodule

// File: rtl/shs_lock_ctrl.sv
`timescale 1ns/1ps
module shs_lock_ctrl #(
  parameter int unsigned LOST_PERIODS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic sync_valid_i,
  input  logic sync_lost_i,
  input  logic expire_i,
  output logic locked_o,
  output logic advance_o,
  output logic restart_o
);
  localparam int unsigned MISS_W = (LOST_PERIODS > 1) ? $clog2(LOST_PERIODS) : 1;
  localparam logic [MISS_W-1:0] MISS_LAST = MISS_W'(LOST_PERIODS - 1);
  localparam logic [MISS_W-1:0] MISS_ONE  = MISS_W'(1);

  logic              locked_q;
  logic [MISS_W-1:0] miss_q;

  // explicit loss while locked; a coincident valid sync keeps the lock
  assign restart_o = run_i && locked_q && sync_lost_i && !sync_valid_i;
  assign advance_o = expire_i && !locked_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_q <= 1'b0;
      miss_q   <= '0;
    end else if (run_i) begin
      if (sync_valid_i) begin
        locked_q <= 1'b1;
        miss_q   <= '0;
      end else if (restart_o) begin
        locked_q <= 1'b0;
        miss_q   <= '0;
      end else if (expire_i && locked_q) begin
        if (miss_q == MISS_LAST) begin
          locked_q <= 1'b0;
          miss_q   <= '0;
        end else begin
          miss_q <= miss_q + MISS_ONE;
        end
      end
    end
  end

  assign locked_o = locked_q;
endmodule

// File: rtl/std_select_hunter.sv
`timescale 1ns/1ps
module std_select_hunter
  import shs_pkg::*;
#(
  parameter int unsigned PERIOD_W     = 8,
  parameter int unsigned LOST_PERIODS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enable_i,
  input  logic                sync_valid_i,
  input  logic                sync_lost_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic [CODE_W-1:0]   code_o,
  output logic                locked_o
);
  logic expire;
  logic advance;
  logic restart;
  logic dwell_clear;

  assign dwell_clear = sync_valid_i || restart;

  shs_dwell_timer #(.PERIOD_W(PERIOD_W)) u_dwell (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (enable_i),
    .clear_i  (dwell_clear),
    .period_i (period_i),
    .expire_o (expire)
  );

  shs_lock_ctrl #(.LOST_PERIODS(LOST_PERIODS)) u_lock (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (enable_i),
    .sync_valid_i (sync_valid_i),
    .sync_lost_i  (sync_lost_i),
    .expire_i     (expire),
    .locked_o     (locked_o),
    .advance_o    (advance),
    .restart_o    (restart)
  );

  shs_code_counter u_code (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (advance),
    .code_o (code_o)
  );
endmodule

// File: rtl/shs_checker.sv
`timescale 1ns/1ps
module shs_checker #(
  parameter int unsigned PERIOD_W = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                enable_i,
  input logic                sync_valid_i,
  input logic                sync_lost_i,
  input logic [PERIOD_W-1:0] period_i,
  input logic [1:0]          code_o,
  input logic                locked_o
);
  assert_step_by_one_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_o != $past(code_o)) |-> (code_o == 2'($past(code_o) + 2'd1)));

  assert_frozen_locked_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(locked_o) |-> $stable(code_o));

  assert_hold_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> ($stable(code_o) && $stable(locked_o)));

  assert_lock_on_sync_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && sync_valid_i) |=> locked_o);

  assert_lock_needs_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(enable_i && sync_valid_i));

  assert_drop_on_lost_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && locked_o && sync_lost_i && !sync_valid_i) |=> !locked_o);

  assert_period_unused_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_i && $stable(period_i)) |=> $stable(code_o));
endmodule

bind std_select_hunter shs_checker #(.PERIOD_W(PERIOD_W)) u_shs_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .enable_i     (enable_i),
  .sync_valid_i (sync_valid_i),
  .sync_lost_i  (sync_lost_i),
  .period_i     (period_i),
  .code_o       (code_o),
  .locked_o     (locked_o)
);

// File: tb/std_select_hunter_bench.sv
`timescale 1ns/1ps
module std_select_hunter_bench;
  localparam int unsigned PW   = 8;
  localparam int unsigned LOST = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          sync_valid = 1'b0;
  logic          sync_lost = 1'b0;
  logic [PW-1:0] period = 8'd5;
  logic [1:0]    code;
  logic          locked;

  int checks = 0;
  int errors = 0;

  // bench reference state
  int m_code = 0, m_dwell = 0, m_miss = 0;
  bit m_locked = 0;

  always #2 clk = ~clk;

  std_select_hunter #(.PERIOD_W(PW), .LOST_PERIODS(LOST)) u_std_select_hunter (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .sync_valid_i(sync_valid),
    .sync_lost_i(sync_lost), .period_i(period), .code_o(code), .locked_o(locked)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int eff_period(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic model(input bit en, input bit sv, input bit sl);
    if (!en) return;
    if (sv) begin
      m_locked = 1; m_miss = 0; m_dwell = 0;
    end else if (m_locked && sl) begin
      m_locked = 0; m_miss = 0; m_dwell = 0;
    end else if (m_dwell + 1 >= eff_period(int'(period))) begin
      m_dwell = 0;
      if (m_locked) begin
        if (m_miss == LOST - 1) begin m_locked = 0; m_miss = 0; end
        else m_miss++;
      end else m_code = (m_code + 1) % 4;
    end else m_dwell++;
  endtask

  task automatic step(input bit en, input bit sv, input bit sl, input string tag);
    @(negedge clk);
    enable = en; sync_valid = sv; sync_lost = sl;
    @(posedge clk);
    model(en, sv, sl);
    #1;
    chk({tag, " code"}, int'(code), m_code);
    chk({tag, " locked"}, int'(locked), int'(m_locked));
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1, 0, 0, tag);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int seed_dummy;
    int held_code, held_lock;
    seed_dummy = $urandom(32'd4711);
    #9;
    chk("R1 code in reset", int'(code), 0);
    chk("R1 locked in reset", int'(locked), 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 code after reset", int'(code), 0);
    chk("R1 locked after reset", int'(locked), 0);

    // R2 / R3: period 5 dwell and wrap
    idle(4, "R2");
    chk("R2 still code 0", int'(code), 0);
    idle(1, "R2");
    chk("R2 advanced to 1", int'(code), 1);
    idle(14, "R3");
    chk("R3 code 3", int'(code), 3);
    idle(1, "R3");
    chk("R3 wrap to 0", int'(code), 0);

    // R9: sync_lost while hunting is ignored
    for (int i = 0; i < 4; i++) step(1, 0, 1, "R9");
    step(1, 0, 0, "R9");
    chk("R9 stepping on schedule", int'(code), 1);

    // R5: sync on the expiry cycle
    idle(4, "R5");
    step(1, 1, 0, "R5");
    chk("R5 no advance on collision", int'(code), 1);
    chk("R5 locked on collision", int'(locked), 1);

    // R6: repeated syncs keep lock
    for (int r = 0; r < 6; r++) begin
      idle(18, "R6");
      step(1, 1, 0, "R6");
    end
    chk("R6 code held", int'(code), 1);
    chk("R6 still locked", int'(locked), 1);

    // R7: timeout after LOST periods
    idle(19, "R7");
    chk("R7 still locked before timeout", int'(locked), 1);
    idle(1, "R7");
    chk("R7 unlocked at timeout", int'(locked), 0);
    chk("R7 code kept", int'(code), 1);
    idle(4, "R7");
    chk("R7 no early advance", int'(code), 1);
    idle(1, "R7");
    chk("R7 advance after full period", int'(code), 2);

    // R4: sync mid-period
    idle(2, "R4");
    step(1, 1, 0, "R4");
    chk("R4 locked", int'(locked), 1);
    chk("R4 code frozen", int'(code), 2);

    // R8: sync_lost with coincident sync keeps lock, alone drops it
    idle(3, "R8");
    step(1, 1, 1, "R8");
    chk("R8 sync beats lost", int'(locked), 1);
    idle(3, "R8");
    step(1, 0, 1, "R8");
    chk("R8 dropped", int'(locked), 0);
    chk("R8 code kept", int'(code), 2);
    idle(4, "R8");
    chk("R8 fresh period", int'(code), 2);
    idle(1, "R8");
    chk("R8 advance", int'(code), 3);

    // R10: disabled freezes everything
    step(1, 1, 0, "R10");
    held_code = int'(code); held_lock = int'(locked);
    for (int i = 0; i < 30; i++) step(0, ($urandom % 2) == 1, ($urandom % 2) == 1, "R10");
    chk("R10 code held", int'(code), held_code);
    chk("R10 locked held", int'(locked), held_lock);
    step(0, 0, 1, "R10");
    chk("R10 lost ignored", int'(locked), 1);

    // random mix, periods 0..6
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 60 == 0) period = PW'($urandom % 7);
      step(($urandom % 10) != 0, ($urandom % 25) == 0, ($urandom % 30) == 0,
           "RAND R2 R5 R7 R8");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule